// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is a single output cell of a small programmable logic device. A sum-of-products term from the logic array reaches the cell. Depending on a static 4-bit configuration word, the cell either passes that term straight to the pin or captures it in a flip-flop first. The configuration word also sets the output polarity, picks which of two clock inputs drives the flip-flop, and chooses where the feedback into the array comes from: the flip-flop or the pin.

The flip-flop has four ways to change state other than normal capture:
- an asynchronous global clear term;
- a synchronous preset term;
- a test preload path, which writes a chosen value without going through the array;
- a power-up clear, driven from the chip reset.

The chip reset is applied at once and released synchronously to the selected clock. The pin is split into a data output, an enable and an input, so that the pad ring can build the three-state driver.

Top module: `omc_cell`

## Requirements
- R1: When cfg[1] is 0 (combinational), pad_o follows sop_in through the polarity stage with no clock involved.
- R2: cfg[0]=1 gives active-high output (pad_o equals the selected value); cfg[0]=0 gives active-low output (pad_o is its inverse).
- R3: When cfg[1] is 1 (registered), pad_o comes from the flip-flop, which takes sop_in on the rising edge of the selected clock and holds it until then.
- R4: cfg[2]=0 clocks the flip-flop from clk_a and cfg[2]=1 from clk_b; edges of the clock that is not selected have no effect on the flip-flop.
- R5: glob_clr high clears the flip-flop at once, with no clock edge, and keeps it cleared while high, even if preset or preload is requested.
- R6: preset_term high, with no preload, sets the flip-flop on the next selected clock edge and not before.
- R7: rst_n low clears the flip-flop at once (power-up clear). After rst_n rises, the first capture happens on the third selected clock edge (SYNC_STAGES=2).
- R8: pl_en high loads pl_val into the flip-flop on the next selected edge, overriding both sop_in and preset_term.
- R9: cfg[3]=0 gives fb_o equal to the true (non-inverted) flip-flop value; cfg[3]=1 gives fb_o equal to pad_i.
- R10: pad_oe equals oe_term, so the pin is driven only while oe_term is high and is otherwise left floating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First clock source |
| clk_b | input | 1 | Second clock source |
| rst_n | input | 1 | Chip reset, active low, applied asynchronously |
| cfg | input | 4 | Static configuration: [0] polarity, [1] registered, [2] clock select, [3] feedback from pin |
| sop_in | input | 1 | Sum-of-products term from the array |
| oe_term | input | 1 | Output-enable term |
| glob_clr | input | 1 | Asynchronous global clear term |
| preset_term | input | 1 | Synchronous preset term |
| pl_en | input | 1 | Test preload enable |
| pl_val | input | 1 | Test preload value |
| pad_i | input | 1 | Value seen at the pin |
| pad_o | output | 1 | Pin data out |
| pad_oe | output | 1 | Pin driver enable |
| fb_o | output | 1 | Feedback into the logic array |

## Verification
The hardest situation to reach from the ports is clk_b being selected while a clk_a edge falls between two clk_b edges. The two clocks share many edges, so a careless test never separates them. The bench runs clk_b at half the rate of clk_a and out of phase with it. It changes sop_in just after a clk_b edge and then samples right after the clk_a edge that comes next. The reset release count is also only visible by holding sop_in high through reset and watching which edge first lets it through.

// File: rtl/omc_pkg.sv
package omc_pkg;
  localparam int unsigned CFG_W = 4;

  typedef struct packed {
    logic fb_pin;
    logic clk_sel_b;
    logic reg_mode;
    logic act_high;
  } cfg_t;
endpackage

// File: rtl/omc_rst_sync.sv
module omc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sh_nxt = 1'b1;
    end else begin : g_chain
      always_comb sh_nxt = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/omc_ff.sv
module omc_ff (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  input  logic preset,
  input  logic pl_en,
  input  logic pl_val,
  output logic q
);
  logic cap_en;
  logic q_nxt;

  assign cap_en = 1'b1;

  always_comb begin
    q_nxt = q;
    if (cap_en) begin
      if (pl_en)       q_nxt = pl_val;
      else if (preset) q_nxt = 1'b1;
      else             q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= 1'b0;
    else         q <= q_nxt;
  end

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (arst_n && !pl_en && !preset) |=> (q == $past(d)));

  // R6
  preset_set_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (arst_n && !pl_en && preset) |=> q);

  // R8
  preload_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (arst_n && pl_en) |=> (q == $past(pl_val)));
endmodule

// File: rtl/omc_route.sv
module omc_route (
  input  omc_pkg::cfg_t cfg,
  input  logic          sop,
  input  logic          q,
  input  logic          pad_i,
  output logic          pad_o,
  output logic          fb_o
);
  logic path_val;

  always_comb begin
    path_val = cfg.reg_mode ? q : sop;
    pad_o    = cfg.act_high ? path_val : ~path_val;
    fb_o     = cfg.fb_pin ? pad_i : q;
  end
endmodule

// File: rtl/omc_cell.sv
module omc_cell #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk_a,
  input  logic                      clk_b,
  input  logic                      rst_n,
  input  logic [omc_pkg::CFG_W-1:0] cfg,
  input  logic                      sop_in,
  input  logic                      oe_term,
  input  logic                      glob_clr,
  input  logic                      preset_term,
  input  logic                      pl_en,
  input  logic                      pl_val,
  input  logic                      pad_i,
  output logic                      pad_o,
  output logic                      pad_oe,
  output logic                      fb_o
);
  import omc_pkg::*;

  cfg_t cfg_s;
  logic ff_clk;
  logic rst_sync_n;
  logic ff_arst_n;
  logic q_reg;

  assign cfg_s = cfg_t'(cfg);

  always_comb ff_clk = cfg_s.clk_sel_b ? clk_b : clk_a;

  omc_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (ff_clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ff_arst_n = rst_sync_n & ~glob_clr;

  omc_ff i_ff (
    .clk    (ff_clk),
    .arst_n (ff_arst_n),
    .d      (sop_in),
    .preset (preset_term),
    .pl_en  (pl_en),
    .pl_val (pl_val),
    .q      (q_reg)
  );

  omc_route i_route (
    .cfg   (cfg_s),
    .sop   (sop_in),
    .q     (q_reg),
    .pad_i (pad_i),
    .pad_o (pad_o),
    .fb_o  (fb_o)
  );

  assign pad_oe = oe_term;

  // R5
  glob_clr_chk: assert property (@(posedge ff_clk) disable iff (!rst_n)
    glob_clr |-> !q_reg);

  // R1
  comb_path_chk: assert property (@(posedge ff_clk) disable iff (!rst_n)
    !cfg_s.reg_mode |-> (pad_o == (cfg_s.act_high ? sop_in : !sop_in)));
endmodule

// File: tb/test_omc_cell.sv
module test_omc_cell;
  logic       clk_a = 1'b0;
  logic       clk_b = 1'b0;
  logic       rst_n;
  logic [3:0] cfg;
  logic       sop_in, oe_term, glob_clr, preset_term, pl_en, pl_val, pad_i;
  logic       pad_o, pad_oe, fb_o;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #4 clk_a = ~clk_a;
  always #8 clk_b = ~clk_b;

  omc_cell i_omc_cell (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .cfg(cfg),
    .sop_in(sop_in), .oe_term(oe_term), .glob_clr(glob_clr),
    .preset_term(preset_term), .pl_en(pl_en), .pl_val(pl_val),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .fb_o(fb_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    if (cfg[2]) @(posedge clk_b);
    else        @(posedge clk_a);
    #2;
  endtask

  task automatic do_reset(input logic [3:0] c);
    cfg = c; sop_in = 0; oe_term = 1; glob_clr = 0; preset_term = 0;
    pl_en = 0; pl_val = 0; pad_i = 0; rst_n = 0;
    repeat (3) @(posedge clk_a);
    #2 rst_n = 1;
    repeat (3) tick();
  endtask

  task automatic t_reset_state();
    do_reset(4'b0011);
    rst_n = 0; sop_in = 1;
    #1 chk("R7 clear while reset low", pad_o, 1'b0);
    chk("R9 fb cleared", fb_o, 1'b0);
    @(posedge clk_a); #2 rst_n = 1;
    tick(); chk("R7 edge1 held", pad_o, 1'b0);
    tick(); chk("R7 edge2 held", pad_o, 1'b0);
    tick(); chk("R7 edge3 captures", pad_o, 1'b1);
  endtask

  task automatic t_comb_polarity();
    do_reset(4'b0001);
    sop_in = 1; #1 chk("R1 comb high", pad_o, 1'b1);
    sop_in = 0; #1 chk("R1 comb low", pad_o, 1'b0);
    cfg = 4'b0000;
    sop_in = 1; #1 chk("R2 active-low of 1", pad_o, 1'b0);
    sop_in = 0; #1 chk("R2 active-low of 0", pad_o, 1'b1);
  endtask

  task automatic t_registered();
    do_reset(4'b0011);
    sop_in = 1; #1 chk("R3 holds before edge", pad_o, 1'b0);
    tick(); chk("R3 captured 1", pad_o, 1'b1);
    sop_in = 0; tick(); chk("R3 captured 0", pad_o, 1'b0);
    do_reset(4'b0010);
    chk("R2 registered active-low idle", pad_o, 1'b1);
    sop_in = 1; tick();
    chk("R2 registered active-low of 1", pad_o, 1'b0);
    chk("R9 fb true value", fb_o, 1'b1);
  endtask

  task automatic t_clock_sel();
    do_reset(4'b0111);
    sop_in = 1;
    @(posedge clk_a); #1 chk("R4 clk_a edge ignored", pad_o, 1'b0);
    tick(); chk("R4 clk_b edge captures", pad_o, 1'b1);
    do_reset(4'b0011);
    sop_in = 1;
    @(posedge clk_a); #1 chk("R4 clk_a selected captures", pad_o, 1'b1);
  endtask

  task automatic t_preset_clear();
    do_reset(4'b0011);
    preset_term = 1; #1 chk("R6 no set before edge", pad_o, 1'b0);
    tick(); chk("R6 set on edge", pad_o, 1'b1);
    preset_term = 0;
    glob_clr = 1; #1 chk("R5 immediate clear", pad_o, 1'b0);
    preset_term = 1; pl_en = 1; pl_val = 1;
    tick(); chk("R5 clear beats preset/preload", pad_o, 1'b0);
    glob_clr = 0; preset_term = 0; pl_en = 0; pl_val = 0;
    tick(); chk("R5 released", pad_o, 1'b0);
  endtask

  task automatic t_preload();
    do_reset(4'b0011);
    pl_en = 1; pl_val = 1; sop_in = 0;
    tick(); chk("R8 load 1 over sop", pad_o, 1'b1);
    pl_val = 0; preset_term = 1;
    tick(); chk("R8 load 0 over preset", pad_o, 1'b0);
    pl_en = 0; preset_term = 0;
  endtask

  task automatic t_feedback_oe();
    do_reset(4'b1011);
    pad_i = 1; #1 chk("R9 fb from pin 1", fb_o, 1'b1);
    pad_i = 0; #1 chk("R9 fb from pin 0", fb_o, 1'b0);
    cfg = 4'b0011; pad_i = 1; #1 chk("R9 fb from register", fb_o, 1'b0);
    oe_term = 0; #1 chk("R10 released", pad_oe, 1'b0);
    oe_term = 1; #1 chk("R10 driven", pad_oe, 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_comb_polarity();
    t_registered();
    t_clock_sel();
    t_preset_clear();
    t_preload();
    t_feedback_oe();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule